// File: doc/BRIEF.md
# Shuffle-Exchange Permutation Network

This block moves N data words from N input lanes to N output lanes through a chain of log2 N switching stages. Each stage first re-wires its lanes with a fixed perfect shuffle (lane j moves to the index obtained by rotating j left by one bit). It then passes adjacent lane pairs through N/2 two-by-two elements. Each element can pass its inputs straight, swap them, or copy one input onto both outputs. Every lane carries a valid bit next to its data word. A lane with no valid source leaves the network as zero data with valid low.

The switch settings come from one of two sources. In configured mode they come from a register that is written as a whole by a load strobe. In self-routing mode each element derives its own setting from the destination address that travels with each input word. Every pattern the network can carry then lands word i on output `dest[i]`. When two words in one element want the same output, the upper word wins, the lower word is dropped and a blocked flag is raised. The data path is combinational by default. A parameter can add one output register stage.

Top module: `shx_net`

## Requirements
- R1: After reset every element is set to straight, so in configured mode output lane i carries input lane i with its valid bit.
- R2: `cfg_word` is captured only on a clock edge where `cfg_load` is high. Between loads the settings hold, whatever `cfg_word` does.
- R3: Ahead of every stage, lane j is wired to lane rotl(j), a one-bit left rotation of the log2 N-bit index. Element e of a stage takes lane 2e as its upper input and lane 2e+1 as its lower input, and drives the same two lanes. Stage 0 is nearest the inputs. The setting of stage s, element e sits at `cfg_word[2*(s*N/2+e) +: 2]`.
- R4: Setting codes: 2'b00 straight, 2'b01 crossover, 2'b10 upper input on both outputs, 2'b11 lower input on both outputs.
- R5: An output whose source is an invalid input, or no input at all, drives all-zero data with valid low.
- R6: With `auto_route` high, stage i steers on destination bit (log2 N − 1 − i): bit value 0 selects the upper output and 1 the lower output. Any set of valid inputs that meets no conflict arrives at output `dest` with its data. No output is valid without a valid source.
- R7: In self-routing mode, if both inputs of an element are valid and need the same output, `blocked` is high. The upper input takes that output and the lower input is discarded.
- R8: `blocked` is low in configured mode and whenever no element sees a conflict.
- R9: With the default `OUT_REG` = 0, outputs follow the inputs and settings within the same cycle, with no clock edge. With `OUT_REG` = 1 they appear one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Capture `cfg_word` into the settings register |
| cfg_word | input | 2·log2N·N/2 | Settings for all elements, two bits each |
| auto_route | input | 1 | 1: self-routing from destination bits; 0: registered settings |
| in_valid | input | N | Valid bit per input lane |
| in_data | input | N·DATA_W | Data word per input lane, lane i at bits [i·DATA_W +: DATA_W] |
| in_dest | input | N·log2N | Destination index per input lane, used in self-routing mode |
| out_valid | output | N | Valid bit per output lane |
| out_data | output | N·DATA_W | Data word per output lane |
| blocked | output | 1 | A self-routed pattern met a conflict |

## Verification
A wrong setting in one element shows at the ports in the same cycle as a swapped, duplicated or missing word on exactly those outputs that the element's subtree feeds. A corrupted settings register stays visible on those lanes until the next load. Faults in the shuffle wiring or in the tag bit that a stage steers on show up as words landing on the wrong output: in configured mode the bench checks the result against a lane-by-lane walk of the stages, and in self-routing mode against output = destination. A faulty conflict rule shows as a wrong `blocked` level or as the lower word surviving in place of the upper one.

// File: rtl/shx_pkg.sv
package shx_pkg;

    typedef enum logic [1:0] {
        SW_STRAIGHT = 2'b00,
        SW_CROSS    = 2'b01,
        SW_UP_BCAST = 2'b10,
        SW_LO_BCAST = 2'b11
    } sw_mode_e;

    // perfect-shuffle destination of lane j in a network of 2**bits lanes
    function automatic int rotl_idx(input int j, input int bits);
        return ((j << 1) | (j >> (bits - 1))) & ((1 << bits) - 1);
    endfunction

endpackage

// File: rtl/shx_cell.sv
module shx_cell
    import shx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int TAG_W  = 3,
    parameter int SEL    = 0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    auto_mode,
    input  logic [1:0]              cfg_set,
    input  logic [DATA_W+TAG_W:0]   up_in,
    input  logic [DATA_W+TAG_W:0]   lo_in,
    output logic [DATA_W+TAG_W:0]   up_out,
    output logic [DATA_W+TAG_W:0]   lo_out,
    output logic                    conflict
);

    typedef struct packed {
        logic              v;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] d;
    } lane_t;

    lane_t    u, l, l_eff, ou, ol, ou_z, ol_z;
    sw_mode_e mode;

    assign u = lane_t'(up_in);
    assign l = lane_t'(lo_in);

    always_comb begin
        conflict = auto_mode && u.v && l.v && (u.tag[SEL] == l.tag[SEL]);
        l_eff    = l;
        if (conflict) l_eff.v = 1'b0;   // upper input keeps the contested output

        if (auto_mode) begin
            if (u.v)        mode = u.tag[SEL] ? SW_CROSS : SW_STRAIGHT;
            else if (l.v)   mode = l.tag[SEL] ? SW_STRAIGHT : SW_CROSS;
            else            mode = SW_STRAIGHT;
        end else begin
            mode = sw_mode_e'(cfg_set);
        end

        unique case (mode)
            SW_STRAIGHT: begin ou = u;     ol = l_eff; end
            SW_CROSS:    begin ou = l_eff; ol = u;     end
            SW_UP_BCAST: begin ou = u;     ol = u;     end
            default:     begin ou = l_eff; ol = l_eff; end
        endcase

        ou_z = ou.v ? ou : '0;
        ol_z = ol.v ? ol : '0;
    end

    assign up_out = ou_z;
    assign lo_out = ol_z;

    // R6: self-routing never creates words
    assert_cell_conserve_R6: assert property (@(posedge clk) disable iff (rst)
        auto_mode |-> ($countones({ou_z.v, ol_z.v}) <= $countones({u.v, l.v})));

    // R6: two non-conflicting valid inputs both leave the element
    assert_cell_pass_both_R6: assert property (@(posedge clk) disable iff (rst)
        (auto_mode && u.v && l.v && !conflict) |-> (ou_z.v && ol_z.v));

    // R7: a conflict leaves exactly one valid output, carrying the upper word
    assert_cell_conflict_drop_R7: assert property (@(posedge clk) disable iff (rst)
        conflict |-> ($countones({ou_z.v, ol_z.v}) == 1 &&
                      (ou_z.v ? ou_z.d : ol_z.d) == u.d));

endmodule

// File: rtl/shx_stage.sv
module shx_stage
    import shx_pkg::*;
#(
    parameter int N_PORTS = 8,
    parameter int DATA_W  = 8,
    parameter int TAG_W   = 3,
    parameter int STAGE   = 0
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  auto_mode,
    input  logic [N_PORTS-1:0]                    cfg_bits,
    input  logic [N_PORTS*(1+TAG_W+DATA_W)-1:0]   lanes_in,
    output logic [N_PORTS*(1+TAG_W+DATA_W)-1:0]   lanes_out,
    output logic                                  conflict_any
);

    localparam int LW   = 1 + TAG_W + DATA_W;
    localparam int HALF = N_PORTS / 2;

    logic [N_PORTS*LW-1:0] shuf;
    logic [HALF-1:0]       cf;

    for (genvar j = 0; j < N_PORTS; j++) begin : g_shuffle
        assign shuf[rotl_idx(j, TAG_W)*LW +: LW] = lanes_in[j*LW +: LW];
    end

    for (genvar e = 0; e < HALF; e++) begin : g_cell
        shx_cell #(
            .DATA_W (DATA_W),
            .TAG_W  (TAG_W),
            .SEL    (TAG_W - 1 - STAGE)
        ) u_cell (
            .clk       (clk),
            .rst       (rst),
            .auto_mode (auto_mode),
            .cfg_set   (cfg_bits[e*2 +: 2]),
            .up_in     (shuf[(2*e)*LW +: LW]),
            .lo_in     (shuf[(2*e+1)*LW +: LW]),
            .up_out    (lanes_out[(2*e)*LW +: LW]),
            .lo_out    (lanes_out[(2*e+1)*LW +: LW]),
            .conflict  (cf[e])
        );
    end

    assign conflict_any = |cf;

endmodule

// File: rtl/shx_net.sv
module shx_net
    import shx_pkg::*;
#(
    parameter int N_PORTS = 8,
    parameter int DATA_W  = 8,
    parameter bit OUT_REG = 1'b0,
    localparam int STAGES = $clog2(N_PORTS),
    localparam int CFG_W  = STAGES * N_PORTS
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cfg_load,
    input  logic [CFG_W-1:0]            cfg_word,
    input  logic                        auto_route,
    input  logic [N_PORTS-1:0]          in_valid,
    input  logic [N_PORTS*DATA_W-1:0]   in_data,
    input  logic [N_PORTS*STAGES-1:0]   in_dest,
    output logic [N_PORTS-1:0]          out_valid,
    output logic [N_PORTS*DATA_W-1:0]   out_data,
    output logic                        blocked
);

    localparam int LW = 1 + STAGES + DATA_W;

    logic [CFG_W-1:0]        cfg_q;
    logic [N_PORTS*LW-1:0]   bus [STAGES+1];
    logic [STAGES-1:0]       stage_cf;
    logic [N_PORTS-1:0]      v_c;
    logic [N_PORTS*DATA_W-1:0] d_c;
    logic                    blk_c;

    always_ff @(posedge clk) begin
        if (rst)           cfg_q <= '0;          // all elements straight
        else if (cfg_load) cfg_q <= cfg_word;
    end

    for (genvar i = 0; i < N_PORTS; i++) begin : g_lane_in
        assign bus[0][i*LW +: LW] = {in_valid[i], in_dest[i*STAGES +: STAGES],
                                     in_data[i*DATA_W +: DATA_W]};
    end

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        shx_stage #(
            .N_PORTS (N_PORTS),
            .DATA_W  (DATA_W),
            .TAG_W   (STAGES),
            .STAGE   (s)
        ) u_stage (
            .clk          (clk),
            .rst          (rst),
            .auto_mode    (auto_route),
            .cfg_bits     (cfg_q[s*N_PORTS +: N_PORTS]),
            .lanes_in     (bus[s]),
            .lanes_out    (bus[s+1]),
            .conflict_any (stage_cf[s])
        );
    end

    for (genvar i = 0; i < N_PORTS; i++) begin : g_lane_out
        assign v_c[i]                  = bus[STAGES][i*LW + LW - 1];
        assign d_c[i*DATA_W +: DATA_W] = bus[STAGES][i*LW +: DATA_W];
    end

    assign blk_c = |stage_cf;

    if (OUT_REG) begin : g_oreg
        always_ff @(posedge clk) begin
            if (rst) begin
                out_valid <= '0;
                out_data  <= '0;
                blocked   <= 1'b0;
            end else begin
                out_valid <= v_c;
                out_data  <= d_c;
                blocked   <= blk_c;
            end
        end
    end else begin : g_ocomb
        assign out_valid = v_c;
        assign out_data  = d_c;
        assign blocked   = blk_c;
    end

    // R2: settings only move after a load or a reset
    assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(cfg_load) && !$past(rst)) |-> $stable(cfg_q));

    // R8: the stages report no conflict while settings come from the register
    assert_blocked_auto_only_R8: assert property (@(posedge clk) disable iff (rst)
        !auto_route |-> !blk_c);

    // R6: self-routing delivers no more words than were offered
    assert_auto_conserve_R6: assert property (@(posedge clk) disable iff (rst)
        auto_route |-> ($countones(v_c) <= $countones(in_valid)));

endmodule

// File: tb/sim_shx_net.sv
module sim_shx_net;

    localparam int N  = 8;
    localparam int DW = 8;
    localparam int S  = 3;
    localparam int CW = S * N;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic            rst, cfg_load, auto_route;
    logic [CW-1:0]   cfg_word;
    logic [N-1:0]    in_valid;
    logic [N*DW-1:0] in_data;
    logic [N*S-1:0]  in_dest;
    logic [N-1:0]    out_valid;
    logic [N*DW-1:0] out_data;
    logic            blocked;

    shx_net #(.N_PORTS(N), .DATA_W(DW)) u0 (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_word(cfg_word),
        .auto_route(auto_route), .in_valid(in_valid), .in_data(in_data),
        .in_dest(in_dest), .out_valid(out_valid), .out_data(out_data),
        .blocked(blocked)
    );

    int n_tests = 0;
    int n_fail  = 0;

    logic [DW-1:0] sd [N];
    logic          sv [N];
    logic [S-1:0]  st [N];
    logic [DW-1:0] ed [N];
    logic          ev [N];

    function automatic int rotl(input int j);
        return ((j << 1) | (j >> (S - 1))) & (N - 1);
    endfunction

    task automatic drive();
        for (int i = 0; i < N; i++) begin
            in_valid[i]          = sv[i];
            in_data[i*DW +: DW]  = sd[i];
            in_dest[i*S +: S]    = st[i];
        end
    endtask

    task automatic check(input string req, input logic exp_blk);
        logic [N-1:0]    xv;
        logic [N*DW-1:0] xd;
        #1;
        for (int i = 0; i < N; i++) begin
            xv[i]         = ev[i];
            xd[i*DW +: DW] = ev[i] ? ed[i] : '0;
        end
        n_tests++;
        if (out_valid !== xv || out_data !== xd || blocked !== exp_blk) begin
            n_fail++;
            $display("FAIL %s: valid=%h data=%h blocked=%b expected valid=%h data=%h blocked=%b",
                     req, out_valid, out_data, blocked, xv, xd, exp_blk);
        end
    endtask

    // walk the lanes stage by stage with the given settings (R3, R4, R5)
    task automatic model_cfg(input logic [CW-1:0] c);
        logic [DW-1:0] cd [N];
        logic          cv [N];
        logic [DW-1:0] td [N];
        logic          tv [N];
        for (int i = 0; i < N; i++) begin cd[i] = sd[i]; cv[i] = sv[i]; end
        for (int s = 0; s < S; s++) begin
            for (int j = 0; j < N; j++) begin td[rotl(j)] = cd[j]; tv[rotl(j)] = cv[j]; end
            for (int e = 0; e < N/2; e++) begin
                logic [1:0] m;
                m = c[2*(s*N/2+e) +: 2];
                case (m)
                    2'b00: begin cv[2*e]=tv[2*e];   cd[2*e]=td[2*e];   cv[2*e+1]=tv[2*e+1]; cd[2*e+1]=td[2*e+1]; end
                    2'b01: begin cv[2*e]=tv[2*e+1]; cd[2*e]=td[2*e+1]; cv[2*e+1]=tv[2*e];   cd[2*e+1]=td[2*e];   end
                    2'b10: begin cv[2*e]=tv[2*e];   cd[2*e]=td[2*e];   cv[2*e+1]=tv[2*e];   cd[2*e+1]=td[2*e];   end
                    default: begin cv[2*e]=tv[2*e+1]; cd[2*e]=td[2*e+1]; cv[2*e+1]=tv[2*e+1]; cd[2*e+1]=td[2*e+1]; end
                endcase
            end
        end
        for (int i = 0; i < N; i++) begin ev[i] = cv[i]; ed[i] = cv[i] ? cd[i] : '0; end
    endtask

    task automatic model_auto();
        for (int i = 0; i < N; i++) begin ev[i] = 1'b0; ed[i] = '0; end
        for (int i = 0; i < N; i++) if (sv[i]) begin ev[st[i]] = 1'b1; ed[st[i]] = sd[i]; end
    endtask

    task automatic load_cfg(input logic [CW-1:0] c);
        @(negedge clk);
        cfg_word = c;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic fill_all_valid(input int base);
        for (int i = 0; i < N; i++) begin sv[i] = 1'b1; sd[i] = DW'(base + 7*i); st[i] = S'(i); end
    endtask

    task automatic t_reset();
        rst = 1'b1; cfg_load = 1'b0; auto_route = 1'b0; cfg_word = '0;
        fill_all_valid(8'h10);
        drive();
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < N; i++) begin ev[i] = 1'b1; ed[i] = sd[i]; end
        check("R1 reset identity (R9 same-cycle)", 1'b0);
    endtask

    task automatic t_settings();
        auto_route = 1'b0;
        fill_all_valid(8'h21); drive();
        load_cfg(24'h555555); model_cfg(24'h555555); check("R3 R4 all crossover", 1'b0);
        load_cfg(24'hAAAAAA); model_cfg(24'hAAAAAA); check("R4 all upper broadcast", 1'b0);
        load_cfg(24'hFFFFFF); model_cfg(24'hFFFFFF); check("R4 all lower broadcast", 1'b0);
        load_cfg(24'hE41B72); model_cfg(24'hE41B72); check("R3 R4 mixed settings", 1'b0);
        fill_all_valid(8'h90); drive();
        model_cfg(24'hE41B72); check("R9 data change without clock edge", 1'b0);
    endtask

    task automatic t_hold();
        auto_route = 1'b0;
        fill_all_valid(8'h33); drive();
        load_cfg(24'h1B4E93);
        @(negedge clk); cfg_word = 24'h6C2D05;
        repeat (2) @(negedge clk);
        model_cfg(24'h1B4E93); check("R2 settings held without load", 1'b0);
        load_cfg(24'h6C2D05);
        model_cfg(24'h6C2D05); check("R2 new settings after load", 1'b0);
    endtask

    task automatic t_invalid();
        auto_route = 1'b0;
        load_cfg(24'h555555);
        fill_all_valid(8'h41);
        sv[1] = 1'b0; sv[2] = 1'b0; sv[6] = 1'b0;
        drive();
        model_cfg(24'h555555); check("R5 invalid lanes zeroed", 1'b0);
        load_cfg(24'hAAAAAA);
        model_cfg(24'hAAAAAA); check("R5 broadcast of invalid lane", 1'b0);
    endtask

    task automatic t_auto();
        @(negedge clk);
        auto_route = 1'b1;
        fill_all_valid(8'h50); drive();
        model_auto(); check("R6 identity destinations", 1'b0);
        for (int i = 0; i < N; i++) st[i] = S'(i + 3);
        drive(); model_auto(); check("R6 shift-by-3 destinations", 1'b0);
        for (int i = 0; i < N; i++) st[i] = ~S'(i);
        drive(); model_auto(); check("R6 complement destinations", 1'b0);
        for (int i = 0; i < N; i++) sv[i] = 1'b0;
        sv[2] = 1'b1; st[2] = 3'd7; sv[5] = 1'b1; st[5] = 3'd1;
        drive(); model_auto(); check("R6 R8 sparse pattern unblocked", 1'b0);
    endtask

    task automatic t_conflict();
        auto_route = 1'b1;
        for (int i = 0; i < N; i++) begin sv[i] = 1'b0; sd[i] = DW'(8'hA0 + i); st[i] = '0; end
        sv[0] = 1'b1; st[0] = 3'd0; sv[4] = 1'b1; st[4] = 3'd1;
        drive();
        for (int i = 0; i < N; i++) begin ev[i] = 1'b0; ed[i] = '0; end
        ev[0] = 1'b1; ed[0] = sd[0];
        check("R7 conflict on upper output, upper wins", 1'b1);
        st[0] = 3'd4; st[4] = 3'd5;
        drive();
        for (int i = 0; i < N; i++) begin ev[i] = 1'b0; ed[i] = '0; end
        ev[4] = 1'b1; ed[4] = sd[0];
        check("R7 conflict on lower output, upper wins", 1'b1);
        @(negedge clk);
        auto_route = 1'b0;
        load_cfg(24'h000000);
        model_cfg(24'h000000);
        check("R8 same tags ignored in configured mode", 1'b0);
    endtask

    initial begin
        in_valid = '0; in_data = '0; in_dest = '0;
        t_reset();
        t_settings();
        t_hold();
        t_invalid();
        t_auto();
        t_conflict();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule